// File: doc/BRIEF.md
# FIFO Error Monitor with Maskable Interrupt

This block sits beside the input and output FIFOs and the register decoder of a crypto unit. It watches their handshake and occupancy signals and catches five faults: an access to an address outside the unit's legal register window, a write to the data size register while the output FIFO still holds data, a done event while the input FIFO still holds data, a push into a full input FIFO, and a pop from an empty output FIFO. Each fault sets its own sticky status bit.

A five-bit mask register chooses which faults drive the single interrupt line. A mask bit of 0 lets its fault through and a mask bit of 1 blocks it. Software reads the status and the mask through a small register port. It clears status bits by writing ones to them. The block also produces qualified push and pop strobes, so that a push into a full FIFO and a pop from an empty FIFO are dropped before they reach the FIFOs.

Top module: `fifo_err_monitor`

## Requirements
- R1: After synchronous reset, err_status is 0, the mask is 0 and irq is low.
- R2: A bus access (bus_valid high, read or write) with bus_addr >= LEGAL_COUNT (default 8) sets err_status bit 0 after the next clock edge. An access below LEGAL_COUNT does not set it.
- R3: size_wr high while out_empty is low sets err_status bit 1. size_wr high while out_empty is high does not set it.
- R4: done_evt high while in_empty is low sets err_status bit 2. done_evt high while in_empty is high does not set it.
- R5: in_push high while in_full is high sets err_status bit 3 and holds in_push_ok low. A push while the FIFO is not full passes to in_push_ok.
- R6: out_pop high while out_empty is high sets err_status bit 4 and holds out_pop_ok low. A pop while the FIFO is not empty passes to out_pop_ok.
- R7: A set status bit stays set until software clears it, even after its condition goes away.
- R8: A bus write to address 0 clears each status bit whose bus_wdata bit is 1 and leaves bits written with 0 alone. A fault in the same cycle as its clear leaves the bit set.
- R9: A bus write to address 1 loads the mask from bus_wdata[4:0]. irq is high exactly when some status bit is 1 and its mask bit is 0.
- R10: During a read, bus_rdata shows the status at address 0 and the mask at address 1. It shows 0 at every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_push | input | 1 | Push request to the input FIFO |
| in_full | input | 1 | Input FIFO full |
| in_empty | input | 1 | Input FIFO empty |
| out_pop | input | 1 | Read request to the output FIFO |
| out_empty | input | 1 | Output FIFO empty |
| size_wr | input | 1 | Strobe for a write to the data size register |
| done_evt | input | 1 | Processing done event |
| bus_valid | input | 1 | Bus access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Word address inside the unit |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Read data |
| in_push_ok | output | 1 | Push passed on to the input FIFO |
| out_pop_ok | output | 1 | Pop passed on to the output FIFO |
| err_status | output | 5 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a fault and its own clear landing in the same cycle. The bench gets there by raising a full-FIFO push in the same cycle as a write of all ones to the status address. The other cross-event faults only appear when an occupancy flag and an unrelated strobe line up. So the bench sweeps each fault under every one of the 32 mask values, and pairs each strobe with its opposite flag to show that no fault is raised. A read sweep over the whole 64-word address space covers the legal window boundary.

// File: rtl/fifo_err_pkg.sv
package fifo_err_pkg;
    localparam int NUM_ERR = 5;

    // Status bit positions (software decodes these)
    localparam int BIT_ADDR     = 0;
    localparam int BIT_OUT_LEFT = 1;
    localparam int BIT_IN_LEFT  = 2;
    localparam int BIT_IN_OVF   = 3;
    localparam int BIT_OUT_UDF  = 4;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_OTHER  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic in_push;
        logic in_full;
        logic in_empty;
        logic out_pop;
        logic out_empty;
        logic size_wr;
        logic done_evt;
    } fifo_obs_t;

    function automatic logic masked_any(err_vec_t st, err_vec_t msk);
        return |(st & ~msk);
    endfunction
endpackage

// File: rtl/fifo_err_detect.sv
module fifo_err_detect
    import fifo_err_pkg::*;
(
    input  fifo_obs_t obs,
    input  logic      addr_bad,
    output err_vec_t  hit,
    output logic      push_ok,
    output logic      pop_ok
);
    always_comb begin
        hit               = '0;
        hit[BIT_ADDR]     = addr_bad;
        hit[BIT_OUT_LEFT] = obs.size_wr  && !obs.out_empty;
        hit[BIT_IN_LEFT]  = obs.done_evt && !obs.in_empty;
        hit[BIT_IN_OVF]   = obs.in_push  && obs.in_full;
        hit[BIT_OUT_UDF]  = obs.out_pop  && obs.out_empty;
        push_ok           = obs.in_push  && !obs.in_full;
        pop_ok            = obs.out_pop  && !obs.out_empty;
    end
endmodule

// File: rtl/fifo_err_sticky.sv
module fifo_err_sticky
    import fifo_err_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  err_vec_t set_vec,
    input  err_vec_t clr_vec,
    output err_vec_t status
);
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (set_vec[i])
                status[i] <= 1'b1;
            else if (clr_vec[i])
                status[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_err_regs.sv
module fifo_err_regs
    import fifo_err_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LEGAL_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  err_vec_t          wdata,
    input  err_vec_t          status,
    output err_vec_t          rdata,
    output err_vec_t          mask,
    output err_vec_t          clr_vec,
    output logic              addr_bad
);
    localparam logic [ADDR_W-1:0] LIMIT    = ADDR_W'(LEGAL_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);

    reg_sel_e sel;

    always_comb begin
        if (addr == A_STATUS)    sel = SEL_STATUS;
        else if (addr == A_MASK) sel = SEL_MASK;
        else                     sel = SEL_OTHER;
    end

    assign addr_bad = valid && (addr >= LIMIT);
    assign clr_vec  = (valid && write && sel == SEL_STATUS) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (valid && write && sel == SEL_MASK)
            mask <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (valid && !write) begin
            unique case (sel)
                SEL_STATUS: rdata = status;
                SEL_MASK:   rdata = mask;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/fifo_err_monitor.sv
module fifo_err_monitor
    import fifo_err_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int LEGAL_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_push,
    input  logic              in_full,
    input  logic              in_empty,
    input  logic              out_pop,
    input  logic              out_empty,
    input  logic              size_wr,
    input  logic              done_evt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [4:0]        bus_wdata,
    output logic [4:0]        bus_rdata,
    output logic              in_push_ok,
    output logic              out_pop_ok,
    output logic [4:0]        err_status,
    output logic              irq
);
    fifo_obs_t obs;
    err_vec_t  hit, clr_vec, mask_q, status_q;
    logic      addr_bad;

    assign obs = '{in_push: in_push, in_full: in_full, in_empty: in_empty,
                   out_pop: out_pop, out_empty: out_empty,
                   size_wr: size_wr, done_evt: done_evt};

    fifo_err_regs #(.ADDR_W(ADDR_W), .LEGAL_COUNT(LEGAL_COUNT)) regs_i (
        .clk(clk), .rst(rst), .valid(bus_valid), .write(bus_write),
        .addr(bus_addr), .wdata(bus_wdata), .status(status_q),
        .rdata(bus_rdata), .mask(mask_q), .clr_vec(clr_vec), .addr_bad(addr_bad)
    );

    fifo_err_detect detect_i (
        .obs(obs), .addr_bad(addr_bad), .hit(hit),
        .push_ok(in_push_ok), .pop_ok(out_pop_ok)
    );

    fifo_err_sticky sticky_i (
        .clk(clk), .rst(rst), .set_vec(hit), .clr_vec(clr_vec), .status(status_q)
    );

    assign err_status = status_q;
    assign irq        = masked_any(status_q, mask_q);
endmodule

// File: rtl/fifo_err_monitor_chk.sv
module fifo_err_monitor_chk #(
    parameter int ADDR_W      = 6,
    parameter int LEGAL_COUNT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_push,
    input logic              in_full,
    input logic              out_pop,
    input logic              out_empty,
    input logic              in_empty,
    input logic              size_wr,
    input logic              done_evt,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [4:0]        err_status,
    input logic [4:0]        mask,
    input logic              irq
);
    logic status_wr;
    assign status_wr = bus_valid && bus_write && (bus_addr == '0);

    assert_addr_err_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_addr >= ADDR_W'(LEGAL_COUNT)) |=> err_status[0]);
    assert_out_left_R3: assert property (@(posedge clk) disable iff (rst)
        (size_wr && !out_empty) |=> err_status[1]);
    assert_in_left_R4: assert property (@(posedge clk) disable iff (rst)
        (done_evt && !in_empty) |=> err_status[2]);
    assert_in_ovf_R5: assert property (@(posedge clk) disable iff (rst)
        (in_push && in_full) |=> err_status[3]);
    assert_out_udf_R6: assert property (@(posedge clk) disable iff (rst)
        (out_pop && out_empty) |=> err_status[4]);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !status_wr |=> ((err_status & $past(err_status)) == $past(err_status)));
    assert_mask_all_R9: assert property (@(posedge clk) disable iff (rst)
        (mask == 5'h1f) |-> !irq);
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (err_status == '0) |-> !irq);
endmodule

bind fifo_err_monitor fifo_err_monitor_chk #(.ADDR_W(ADDR_W), .LEGAL_COUNT(LEGAL_COUNT)) chk_i (
    .clk(clk), .rst(rst), .in_push(in_push), .in_full(in_full),
    .out_pop(out_pop), .out_empty(out_empty), .in_empty(in_empty),
    .size_wr(size_wr), .done_evt(done_evt), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .err_status(err_status),
    .mask(mask_q), .irq(irq)
);

// File: tb/fifo_err_monitor_tb.sv
module fifo_err_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int LEGAL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_push = 0, in_full = 0, in_empty = 1, out_pop = 0, out_empty = 1;
    logic size_wr = 0, done_evt = 0, bus_valid = 0, bus_write = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [4:0] bus_wdata = '0;
    logic [4:0] bus_rdata, err_status;
    logic in_push_ok, out_pop_ok, irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_err_monitor #(.ADDR_W(AW), .LEGAL_COUNT(LEGAL)) dut_i (
        .clk(clk), .rst(rst), .in_push(in_push), .in_full(in_full),
        .in_empty(in_empty), .out_pop(out_pop), .out_empty(out_empty),
        .size_wr(size_wr), .done_evt(done_evt), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .in_push_ok(in_push_ok), .out_pop_ok(out_pop_ok),
        .err_status(err_status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_push = 0; in_full = 0; in_empty = 1; out_pop = 0; out_empty = 1;
        size_wr = 0; done_evt = 0; bus_valid = 0; bus_write = 0;
        bus_addr = '0; bus_wdata = '0;
    endtask

    // inputs applied at negedge take effect at next posedge; sample at following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [4:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic fire(input int e);
        case (e)
            0: begin bus_valid = 1; bus_addr = AW'(LEGAL); end
            1: begin size_wr = 1; out_empty = 0; end
            2: begin done_evt = 1; in_empty = 0; end
            3: begin in_push = 1; in_full = 1; end
            default: begin out_pop = 1; out_empty = 1; end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 status", err_status, 0);
        check("R1 irq", irq, 0);
        bus_valid = 1; bus_addr = 1; #1;
        check("R1 mask read", bus_rdata, 0);
        idle();

        // R2..R6, R9: every fault under every mask value
        for (int m = 0; m < 32; m++) begin
            bus_wr(1, 5'(m));
            for (int e = 0; e < 5; e++) begin
                bus_wr(0, 5'h1f);
                fire(e);
                step();
                check($sformatf("R%0d status m=%0d", e + 2, m), err_status, 32'(1 << e));
                check($sformatf("R9 irq m=%0d e=%0d", m, e), irq, ((m >> e) & 1) == 0);
            end
        end
        bus_wr(1, 5'h00);
        bus_wr(0, 5'h1f);

        // negative pairings R3 R4 R5 R6
        size_wr = 1; out_empty = 1; step();
        check("R3 no flag when out empty", err_status, 0);
        done_evt = 1; in_empty = 1; step();
        check("R4 no flag when in empty", err_status, 0);
        in_push = 1; in_full = 0; #1;
        check("R5 push passes", in_push_ok, 1);
        step();
        check("R5 no flag when not full", err_status, 0);
        in_push = 1; in_full = 1; #1;
        check("R5 push dropped", in_push_ok, 0);
        out_pop = 1; out_empty = 0; #1;
        check("R6 pop passes", out_pop_ok, 1);
        idle(); out_pop = 1; out_empty = 1; #1;
        check("R6 pop dropped", out_pop_ok, 0);
        step();
        check("R6 status", err_status, 5'h10);

        // R7 sticky across idle cycles; R8 partial clear
        fire(3); step();
        repeat (4) step();
        check("R7 sticky", err_status, 5'h18);
        bus_wr(0, 5'h08);
        check("R8 partial clear", err_status, 5'h10);
        // R8 set wins over same-cycle clear
        bus_valid = 1; bus_write = 1; bus_addr = 0; bus_wdata = 5'h1f;
        in_push = 1; in_full = 1;
        step();
        check("R8 set wins", err_status, 5'h08);
        bus_wr(0, 5'h1f);

        // R10 + R2: read sweep of whole address space
        bus_wr(1, 5'h15);
        for (int a = 0; a < (1 << AW); a++) begin
            bus_wr(0, 5'h1f);
            fire(4); step();
            bus_valid = 1; bus_write = 0; bus_addr = AW'(a); #1;
            check($sformatf("R10 rdata a=%0d", a), bus_rdata,
                  (a == 0) ? 32'h10 : (a == 1) ? 32'h15 : 32'h0);
            step();
            check($sformatf("R2 a=%0d", a), err_status[0], a >= LEGAL);
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule